// File: doc/BRIEF.md
# Two-Channel DC Offset Removal Highpass Filter

This block removes the DC offset from a stream of signed 24-bit PCM audio samples carrying two channels. Each sample arrives with a valid strobe and a channel tag. The block keeps a separate offset estimate for each channel in a leaky integrator and subtracts that estimate from every sample. The result is a first-order IIR highpass. With a shift of 14, the step size is 2^-14 per sample. That puts the -3 dB corner near 0.47 Hz at 48 kHz, and the corner moves in proportion to the sample rate.

A single enable input selects between two behaviours:
- **Enable high:** the estimate keeps following the input, so the filter tracks continuously.
- **Enable low:** each channel's estimate is frozen at its last value and is still subtracted from every sample. The offset stays removed, but the frequency response is no longer shaped.

A typical use is to raise the enable for a few seconds to learn the offset and then lower it. The stage then works as an acquire-and-hold offset canceller.

The filtered sample appears one clock after its input, with its own valid strobe and the unchanged channel tag. The result of the subtraction is saturated to the signed 24-bit range.

Top module: `dcblk_hpf`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` and sets both channel offset estimates to zero. The first sample of each channel after reset therefore leaves the block unchanged.
- R2: `out_valid` is high exactly one clock after a cycle with `in_valid` high. `out_chan` in that cycle equals the `in_chan` of that input sample, where 0 is the left channel and 1 is the right channel.
- R3: Each channel holds an estimate `E` with FRAC_W fractional bits. The integer offset is `D = floor(E / 2^FRAC_W)`. For each sample `x` (two's complement), the output is `x - D`, where `D` is the estimate from before this sample's update.
- R4: While `enable` is high, each valid sample updates the estimate of its own channel as `E += floor((x*2^FRAC_W - E) / 2^SHIFT)`.
- R5: While `enable` is low, no estimate changes. The held integer offset is still subtracted from every valid sample.
- R6: When `x - D` falls outside the signed range, the output clips to +8388607 or -8388608 instead of wrapping.
- R7: A sample of one channel never alters the estimate of the other channel.
- R8: In a cycle with `in_valid` low, no estimate changes, whatever `in_data`, `in_chan` and `enable` carry. In the following cycle `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | 1 | Channel tag of the input sample (0 left, 1 right) |
| in_data | input | 24 | Signed input sample |
| enable | input | 1 | High: track the offset; low: hold and keep subtracting |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | 1 | Channel tag of the output sample |
| out_data | output | 24 | Signed filtered, saturated sample |

## Verification
The bench builds the block with SHIFT set to 4, FRAC_W at 14, 24-bit samples and two channels. The short time constant lets an estimate settle within a few hundred samples. Within that reach the bench can drive an estimate up against a rail and then apply the opposite full-scale value, which forces clipping. It can also freeze a large learned offset and confirm that the offset is still subtracted. Random runs interleave the two channels, toggle the enable, and insert idle cycles that carry junk data.

// File: rtl/dcblk_pkg.sv
package dcblk_pkg;

    localparam int DEF_SAMPLE_W = 24;
    localparam int DEF_FRAC_W   = 14;
    localparam int DEF_SHIFT    = 14;
    localparam int DEF_NUM_CH   = 2;

    // Channel tag values on the stream
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    // Width of one offset accumulator: sample bits plus guard bits
    function automatic int acc_width(input int sample_w, input int frac_w);
        return sample_w + frac_w;
    endfunction

    // Width of a channel tag for a given number of channels
    function automatic int tag_width(input int num_ch);
        return (num_ch > 1) ? $clog2(num_ch) : 1;
    endfunction

endpackage

// File: rtl/dcblk_sat_sub.sv
module dcblk_sat_sub #(
    parameter int W = dcblk_pkg::DEF_SAMPLE_W
) (
    input  logic signed [W-1:0] minuend,
    input  logic signed [W-1:0] subtrahend,
    output logic signed [W-1:0] result
);
    localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] diff;

    always_comb begin
        diff = {minuend[W-1], minuend} - {subtrahend[W-1], subtrahend};
        if (diff[W] != diff[W-1]) begin
            result = diff[W] ? MIN_V : MAX_V;
        end else begin
            result = diff[W-1:0];
        end
    end
endmodule

// File: rtl/dcblk_tracker.sv
module dcblk_tracker #(
    parameter int NUM_CH   = dcblk_pkg::DEF_NUM_CH,
    parameter int SAMPLE_W = dcblk_pkg::DEF_SAMPLE_W,
    parameter int FRAC_W   = dcblk_pkg::DEF_FRAC_W,
    parameter int SHIFT    = dcblk_pkg::DEF_SHIFT,
    localparam int ACC_W   = dcblk_pkg::acc_width(SAMPLE_W, FRAC_W),
    localparam int CH_W    = dcblk_pkg::tag_width(NUM_CH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       upd_valid,
    input  logic [CH_W-1:0]            upd_chan,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic                       enable,
    output logic signed [SAMPLE_W-1:0] dc_sel,
    output logic [NUM_CH*ACC_W-1:0]    est_flat
);
    logic signed [ACC_W-1:0] acc [NUM_CH];
    logic signed [ACC_W:0]   x_scaled;
    logic signed [ACC_W-1:0] acc_sel;

    assign x_scaled = {sample[SAMPLE_W-1], sample, {FRAC_W{1'b0}}};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic signed [ACC_W:0] err;
        logic signed [ACC_W:0] step;

        always_comb begin
            err  = x_scaled - {acc[c][ACC_W-1], acc[c]};
            step = err >>> SHIFT;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                acc[c] <= '0;
            end else if (upd_valid && enable && (upd_chan == CH_W'(c))) begin
                acc[c] <= acc[c] + step[ACC_W-1:0];
            end
        end

        assign est_flat[c*ACC_W +: ACC_W] = acc[c];
    end

    assign acc_sel = acc[upd_chan];
    assign dc_sel  = acc_sel[ACC_W-1:FRAC_W];
endmodule

// File: rtl/dcblk_hpf.sv
module dcblk_hpf #(
    parameter int NUM_CH   = dcblk_pkg::DEF_NUM_CH,
    parameter int SAMPLE_W = dcblk_pkg::DEF_SAMPLE_W,
    parameter int FRAC_W   = dcblk_pkg::DEF_FRAC_W,
    parameter int SHIFT    = dcblk_pkg::DEF_SHIFT,
    localparam int ACC_W   = dcblk_pkg::acc_width(SAMPLE_W, FRAC_W),
    localparam int CH_W    = dcblk_pkg::tag_width(NUM_CH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [CH_W-1:0]            in_chan,
    input  logic signed [SAMPLE_W-1:0] in_data,
    input  logic                       enable,
    output logic                       out_valid,
    output logic [CH_W-1:0]            out_chan,
    output logic signed [SAMPLE_W-1:0] out_data
);
    logic signed [SAMPLE_W-1:0] dc_now;
    logic signed [SAMPLE_W-1:0] clean;
    logic [NUM_CH*ACC_W-1:0]    est_flat;

    dcblk_tracker #(
        .NUM_CH  (NUM_CH),
        .SAMPLE_W(SAMPLE_W),
        .FRAC_W  (FRAC_W),
        .SHIFT   (SHIFT)
    ) tracker_i (
        .clk      (clk),
        .rst      (rst),
        .upd_valid(in_valid),
        .upd_chan (in_chan),
        .sample   (in_data),
        .enable   (enable),
        .dc_sel   (dc_now),
        .est_flat (est_flat)
    );

    dcblk_sat_sub #(.W(SAMPLE_W)) sub_i (
        .minuend   (in_data),
        .subtrahend(dc_now),
        .result    (clean)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_chan <= in_chan;
                out_data <= clean;
            end
        end
    end
endmodule

// File: rtl/dcblk_hpf_chk.sv
module dcblk_hpf_chk #(
    parameter int NUM_CH = 2,
    parameter int ACC_W  = 38,
    parameter int CH_W   = 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [CH_W-1:0]         in_chan,
    input logic                    enable,
    input logic                    out_valid,
    input logic [CH_W-1:0]         out_chan,
    input logic [NUM_CH*ACC_W-1:0] est_flat
);
    // R1
    reset_clears_valid_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    chan_carry_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_chan == $past(in_chan)));

    // R5
    frozen_estimate_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(est_flat));

    // R8
    idle_no_update_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(est_flat) && !out_valid));
endmodule

bind dcblk_hpf dcblk_hpf_chk #(
    .NUM_CH(NUM_CH),
    .ACC_W (ACC_W),
    .CH_W  (CH_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_chan  (in_chan),
    .enable   (enable),
    .out_valid(out_valid),
    .out_chan (out_chan),
    .est_flat (est_flat)
);

// File: tb/dcblk_hpf_tb_top.sv
module dcblk_hpf_tb_top;
    import dcblk_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int SW   = 24;
    localparam int FW   = 14;
    localparam int SH   = 4;
    localparam longint MAXV = 64'sd8388607;
    localparam longint MINV = -64'sd8388608;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_chan = 1'b0;
    logic signed [SW-1:0] in_data = '0;
    logic enable = 1'b0;
    logic out_valid;
    logic out_chan;
    logic signed [SW-1:0] out_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    longint acc_m [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dcblk_hpf #(.NUM_CH(2), .SAMPLE_W(SW), .FRAC_W(FW), .SHIFT(SH)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
        .in_data(in_data), .enable(enable), .out_valid(out_valid),
        .out_chan(out_chan), .out_data(out_data)
    );

    function automatic longint clamp(input longint v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    // Output the model predicts for channel ch and sample x, using the estimate before the update
    function automatic longint predict(input int ch, input longint x);
        return clamp(x - (acc_m[ch] >>> FW));
    endfunction

    // Estimate update applied by the model while tracking is enabled
    function automatic void model_update(input int ch, input longint x, input bit en);
        if (en) acc_m[ch] = acc_m[ch] + (((x <<< FW) - acc_m[ch]) >>> SH);
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one sample at a falling edge; check the result at the next falling edge
    task automatic send(input int ch, input longint x, input bit en, input string tag);
        longint exp;
        in_valid = 1'b1;
        in_chan  = ch[0];
        in_data  = x[SW-1:0];
        enable   = en;
        exp = predict(ch, x);
        model_update(ch, x, en);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, longint'(out_valid), 1);
        check({tag, " chan"}, longint'(out_chan), longint'(ch));
        check({tag, " data"}, longint'(out_data), exp);
    endtask

    // Cycle with no valid sample and junk on the other inputs
    task automatic idle(input string tag);
        in_valid = 1'b0;
        in_chan  = 1'($urandom);
        in_data  = SW'($urandom);
        enable   = 1'($urandom);
        @(negedge clk);
        check({tag, " idle valid"}, longint'(out_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        longint v;
        longint prev;
        void'($urandom(32'd1234));
        acc_m[0] = 0;
        acc_m[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: after reset the output strobe is low
        check("R1 reset valid", longint'(out_valid), 0);
        // R1: the first sample of each channel leaves unchanged
        send(CH_LEFT, 64'sd123456, 1'b1, "R1 first left");
        check("R1 pass left", longint'(out_data), 64'sd123456);
        send(CH_RIGHT, -64'sd777, 1'b1, "R1 first right");
        check("R1 pass right", longint'(out_data), -64'sd777);

        // R4 R7: a positive offset on the left, a negative one on the right, interleaved
        for (int i = 0; i < 150; i++) begin
            send(CH_LEFT, 64'sd50000 + longint'($urandom_range(0, 200)) - 100, 1'b1, "R4 track left");
            send(CH_RIGHT, -64'sd30000 + longint'($urandom_range(0, 200)) - 100, 1'b1, "R7 track right");
        end
        // R4: after settling, the residual is small
        send(CH_LEFT, 64'sd50000, 1'b1, "R4 settled");
        check("R4 residual small", longint'(out_data > -24'sd300 && out_data < 24'sd300), 1);

        // R5: freeze, then feed zeros; the output must be the negated held offset, unchanged
        send(CH_RIGHT, 0, 1'b0, "R5 hold first");
        prev = longint'(out_data);
        check("R5 offset still removed", longint'(prev > 64'sd29000), 1);
        for (int i = 0; i < 20; i++) begin
            send(CH_RIGHT, 0, 1'b0, "R5 hold");
            check("R5 held constant", longint'(out_data), prev);
        end

        // R8: idle cycles with junk leave the estimates untouched
        for (int i = 0; i < 10; i++) idle("R8");
        send(CH_RIGHT, 0, 1'b0, "R8 after idle");
        check("R8 estimate kept", longint'(out_data), prev);

        // R6: drive the left estimate near the positive rail, then apply the negative rail
        for (int i = 0; i < 300; i++) send(CH_LEFT, MAXV, 1'b1, "R6 charge");
        send(CH_LEFT, MINV, 1'b0, "R6 clip low");
        check("R6 clip low value", longint'(out_data), MINV);
        for (int i = 0; i < 300; i++) send(CH_RIGHT, MINV, 1'b1, "R6 charge neg");
        send(CH_RIGHT, MAXV, 1'b0, "R6 clip high");
        check("R6 clip high value", longint'(out_data), MAXV);

        // R3 R4 R5 R7 R8: random mix
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 9) == 0) begin
                idle("R8 rand");
            end else begin
                v = longint'($signed(SW'($urandom)));
                if ($urandom_range(0, 3) != 0) v = v >>> 3;
                send(int'($urandom_range(0, 1)), v, 1'($urandom_range(0, 3) != 0), "R3 rand");
            end
        end

        // R1: a reset in mid-stream clears the estimates again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        acc_m[0] = 0;
        acc_m[1] = 0;
        check("R1 reset again valid", longint'(out_valid), 0);
        send(CH_LEFT, 64'sd4242, 1'b1, "R1 after reset");
        check("R1 passthrough", longint'(out_data), 64'sd4242);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule